// File: doc/BRIEF.md
# Early Branch Target Resolver

This block sits in the decode path of a multi-lane, multithreaded front end. Each cycle it takes a bundle of up to `LANES` instructions in program order. It forwards them one cycle later and checks their branch predictions early. A direct unconditional branch has a target that is known once decode has run. When that target differs from the address the predictor chose, the block issues a complete redirect record to fetch. It corrects the prediction carried by the branch. It kills the younger instructions of the same thread that follow the branch in the bundle.

The block also catches an instruction that was predicted taken but is not a control transfer. This is a control misprediction: it stops the bundle in the same way and is reported on its own error pulse. Each forwarded instruction that reads no source registers is marked ready to issue. Three counters report resolved branches, branch mispredictions and control mispredictions. Instruction size is 4 bytes and addresses are 32 bits wide.

Top module: `early_branch_resolver`

## Requirements
- R1: A valid lane at or before the stop lane (the first lane that raises a branch mispredict or a control mispredict) appears on `out_valid` one cycle after it is presented, with its `seq`, `pc` and `tid` unchanged. When no lane stops, every valid lane is forwarded.
- R2: `out_ready` of a forwarded lane is 1 exactly when its source count is 0.
- R3: `cnt_resolved` increases by the number of forwarded lanes that are control, direct and unconditional, whether or not their prediction was right. Conditional or indirect branches are never resolved and never redirect.
- R4: A resolved branch whose target differs from its predicted PC raises `rd_valid` for one cycle. The mispredict, prediction-wrong and squash flags are 1, and `rd_tid`/`rd_seq` are the branch's. `rd_npc` equals the target, `rd_nnpc` equals the target plus 4, and `rd_upc` is 0.
- R5: `rd_taken` is 1 exactly when the branch's next PC differs from its PC plus 4.
- R6: The forwarded predicted PC of a mispredicted branch equals its target. For every other forwarded lane it equals the input predicted PC.
- R7: Only the lowest-numbered stop lane acts. Valid lanes after it are not forwarded. Among them, a lane of the same thread with a larger sequence number is set in `kill_mask`, and every other one is set in `hold_mask`.
- R8: A valid lane predicted taken whose control bit is 0 raises `cerr_valid` for one cycle with its `seq` and `tid`, stops the bundle as in R7, and raises no redirect. The lane itself is forwarded.
- R9: `cnt_mispred` and `cnt_ctrl_err` each increase by one in the cycle of every `rd_valid` and `cerr_valid` pulse respectively.
- R10: After reset all valid outputs, masks and counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | LANES | Lane holds an instruction |
| in_tid | input | LANES*TID_W | Thread of each lane |
| in_seq | input | LANES*SEQ_W | Sequence number of each lane |
| in_pc | input | LANES*32 | Instruction address |
| in_npc | input | LANES*32 | Next address recorded by fetch |
| in_pred_pc | input | LANES*32 | Predicted next address |
| in_target | input | LANES*32 | Computed branch target |
| in_pred_taken | input | LANES | Predicted taken |
| in_is_ctrl | input | LANES | Control-transfer instruction |
| in_is_direct | input | LANES | Direct (PC-relative) target |
| in_is_uncond | input | LANES | Unconditional transfer |
| in_nsrc | input | LANES*NSRC_W | Source register count |
| out_valid | output | LANES | Forwarded lane valid |
| out_tid | output | LANES*TID_W | Forwarded thread |
| out_seq | output | LANES*SEQ_W | Forwarded sequence number |
| out_pc | output | LANES*32 | Forwarded address |
| out_pred_pc | output | LANES*32 | Forwarded, corrected predicted address |
| out_ready | output | LANES | Ready to issue (no sources) |
| kill_mask | output | LANES | Lanes squashed as younger same-thread |
| hold_mask | output | LANES | Lanes not processed after a stop |
| rd_valid | output | 1 | Redirect pulse |
| rd_mispredict | output | 1 | Redirect flag: branch mispredict |
| rd_pred_wrong | output | 1 | Redirect flag: prediction incorrect |
| rd_squash | output | 1 | Redirect flag: squash younger |
| rd_tid | output | TID_W | Thread of the redirect |
| rd_seq | output | SEQ_W | Sequence number of the last good instruction |
| rd_npc | output | 32 | Corrected next address |
| rd_nnpc | output | 32 | Address after the corrected next |
| rd_taken | output | 1 | Branch recorded as taken by fetch |
| rd_upc | output | UPC_W | Micro-PC after the branch |
| cerr_valid | output | 1 | Control-mispredict pulse |
| cerr_tid | output | TID_W | Thread of the faulting lane |
| cerr_seq | output | SEQ_W | Sequence number of the faulting lane |
| cnt_resolved | output | CNT_W | Resolved branch count |
| cnt_mispred | output | CNT_W | Branch mispredict count |
| cnt_ctrl_err | output | CNT_W | Control mispredict count |

## Verification
The hardest case to reach from the ports is a bundle where several lanes could stop it at once. One example is a control mispredict ahead of a branch mispredict, or two mispredicted branches. The trailing lanes then mix the stopping thread, another thread and an older sequence number. The stimulus builds such bundles lane by lane, so that kill and hold, priority and counting are each decided by a single lane field. It also sends redirect bundles back to back, to show that the pulses and counters follow each cycle on its own.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
  localparam int PC_W       = 32;
  localparam int INST_BYTES = 4;

  // Sequential successor of an address.
  function automatic logic [PC_W-1:0] seq_pc(input logic [PC_W-1:0] pc);
    return pc + PC_W'(INST_BYTES);
  endfunction

  // Fetch recorded a non-sequential next address.
  function automatic logic left_sequence(input logic [PC_W-1:0] pc,
                                         input logic [PC_W-1:0] npc);
    return npc != seq_pc(pc);
  endfunction
endpackage

// File: rtl/ebr_lane_eval.sv
module ebr_lane_eval
  import ebr_pkg::*;
#(
  parameter int NSRC_W = 3
) (
  input  logic              valid,
  input  logic              is_ctrl,
  input  logic              is_direct,
  input  logic              is_uncond,
  input  logic              pred_taken,
  input  logic [PC_W-1:0]   target,
  input  logic [PC_W-1:0]   pred_pc,
  input  logic [NSRC_W-1:0] nsrc,
  output logic              resolve,
  output logic              mispred,
  output logic              ctrl_err,
  output logic              ready,
  output logic [PC_W-1:0]   pred_fixed
);
  assign resolve    = valid && is_ctrl && is_direct && is_uncond;
  assign mispred    = resolve && (target != pred_pc);
  assign ctrl_err   = valid && pred_taken && !is_ctrl;
  assign ready      = (nsrc == '0);
  assign pred_fixed = mispred ? target : pred_pc;
endmodule

// File: rtl/ebr_stop_pick.sv
module ebr_stop_pick #(
  parameter int LANES = 4,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] stop_req,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic [LANES-1:0] proc_mask
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (stop_req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    for (int i = 0; i < LANES; i++) begin
      proc_mask[i] = !found || (i <= int'(idx));
    end
  end
endmodule

// File: rtl/ebr_squash_mask.sv
module ebr_squash_mask #(
  parameter int LANES = 4,
  parameter int TID_W = 1,
  parameter int SEQ_W = 16,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                        found,
  input  logic [IDX_W-1:0]            idx,
  input  logic [LANES-1:0]            valid,
  input  logic [LANES-1:0][TID_W-1:0] tid,
  input  logic [LANES-1:0][SEQ_W-1:0] seq,
  output logic [LANES-1:0]            kill,
  output logic [LANES-1:0]            hold
);
  logic [TID_W-1:0] ref_tid;
  logic [SEQ_W-1:0] ref_seq;

  assign ref_tid = tid[idx];
  assign ref_seq = seq[idx];

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic after;
      logic younger;
      assign after   = found && (g > int'(idx)) && valid[g];
      assign younger = (tid[g] == ref_tid) && (seq[g] > ref_seq);
      assign kill[g] = after && younger;
      assign hold[g] = after && !younger;
    end
  endgenerate
endmodule

// File: rtl/early_branch_resolver.sv
module early_branch_resolver
  import ebr_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int TID_W  = 1,
  parameter int SEQ_W  = 16,
  parameter int NSRC_W = 3,
  parameter int UPC_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        in_valid,
  input  logic [LANES*TID_W-1:0]  in_tid,
  input  logic [LANES*SEQ_W-1:0]  in_seq,
  input  logic [LANES*PC_W-1:0]   in_pc,
  input  logic [LANES*PC_W-1:0]   in_npc,
  input  logic [LANES*PC_W-1:0]   in_pred_pc,
  input  logic [LANES*PC_W-1:0]   in_target,
  input  logic [LANES-1:0]        in_pred_taken,
  input  logic [LANES-1:0]        in_is_ctrl,
  input  logic [LANES-1:0]        in_is_direct,
  input  logic [LANES-1:0]        in_is_uncond,
  input  logic [LANES*NSRC_W-1:0] in_nsrc,
  output logic [LANES-1:0]        out_valid,
  output logic [LANES*TID_W-1:0]  out_tid,
  output logic [LANES*SEQ_W-1:0]  out_seq,
  output logic [LANES*PC_W-1:0]   out_pc,
  output logic [LANES*PC_W-1:0]   out_pred_pc,
  output logic [LANES-1:0]        out_ready,
  output logic [LANES-1:0]        kill_mask,
  output logic [LANES-1:0]        hold_mask,
  output logic                    rd_valid,
  output logic                    rd_mispredict,
  output logic                    rd_pred_wrong,
  output logic                    rd_squash,
  output logic [TID_W-1:0]        rd_tid,
  output logic [SEQ_W-1:0]        rd_seq,
  output logic [PC_W-1:0]         rd_npc,
  output logic [PC_W-1:0]         rd_nnpc,
  output logic                    rd_taken,
  output logic [UPC_W-1:0]        rd_upc,
  output logic                    cerr_valid,
  output logic [TID_W-1:0]        cerr_tid,
  output logic [SEQ_W-1:0]        cerr_seq,
  output logic [CNT_W-1:0]        cnt_resolved,
  output logic [CNT_W-1:0]        cnt_mispred,
  output logic [CNT_W-1:0]        cnt_ctrl_err
);
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANES-1:0][TID_W-1:0]  tid_a;
  logic [LANES-1:0][SEQ_W-1:0]  seq_a;
  logic [LANES-1:0][PC_W-1:0]   pc_a, npc_a, pp_a, tgt_a, pp_fix;
  logic [LANES-1:0][NSRC_W-1:0] nsrc_a;

  assign tid_a  = in_tid;
  assign seq_a  = in_seq;
  assign pc_a   = in_pc;
  assign npc_a  = in_npc;
  assign pp_a   = in_pred_pc;
  assign tgt_a  = in_target;
  assign nsrc_a = in_nsrc;

  // Named per-lane events
  logic [LANES-1:0] ev_resolve, ev_mispred, ev_ctrl_err, lane_ready;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_eval
      ebr_lane_eval #(.NSRC_W(NSRC_W)) u_eval (
        .valid      (in_valid[g]),
        .is_ctrl    (in_is_ctrl[g]),
        .is_direct  (in_is_direct[g]),
        .is_uncond  (in_is_uncond[g]),
        .pred_taken (in_pred_taken[g]),
        .target     (tgt_a[g]),
        .pred_pc    (pp_a[g]),
        .nsrc       (nsrc_a[g]),
        .resolve    (ev_resolve[g]),
        .mispred    (ev_mispred[g]),
        .ctrl_err   (ev_ctrl_err[g]),
        .ready      (lane_ready[g]),
        .pred_fixed (pp_fix[g])
      );
    end
  endgenerate

  logic [LANES-1:0] stop_req, proc_mask, kill_n, hold_n, fwd_valid;
  logic             stop_found;
  logic [IDX_W-1:0] stop_idx;

  assign stop_req = ev_mispred | ev_ctrl_err;

  ebr_stop_pick #(.LANES(LANES)) u_pick (
    .stop_req  (stop_req),
    .found     (stop_found),
    .idx       (stop_idx),
    .proc_mask (proc_mask)
  );

  ebr_squash_mask #(.LANES(LANES), .TID_W(TID_W), .SEQ_W(SEQ_W)) u_squash (
    .found (stop_found),
    .idx   (stop_idx),
    .valid (in_valid),
    .tid   (tid_a),
    .seq   (seq_a),
    .kill  (kill_n),
    .hold  (hold_n)
  );

  assign fwd_valid = in_valid & proc_mask;

  logic stop_is_br, stop_is_cerr;
  assign stop_is_br   = stop_found && ev_mispred[stop_idx];
  assign stop_is_cerr = stop_found && ev_ctrl_err[stop_idx];

  logic [CNT_W-1:0] res_add;
  always_comb begin
    res_add = '0;
    for (int i = 0; i < LANES; i++) begin
      res_add = res_add + CNT_W'(ev_resolve[i] && proc_mask[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= '0;
      out_tid      <= '0;
      out_seq      <= '0;
      out_pc       <= '0;
      out_pred_pc  <= '0;
      out_ready    <= '0;
      kill_mask    <= '0;
      hold_mask    <= '0;
      rd_valid     <= 1'b0;
      rd_tid       <= '0;
      rd_seq       <= '0;
      rd_npc       <= '0;
      rd_nnpc      <= '0;
      rd_taken     <= 1'b0;
      cerr_valid   <= 1'b0;
      cerr_tid     <= '0;
      cerr_seq     <= '0;
      cnt_resolved <= '0;
      cnt_mispred  <= '0;
      cnt_ctrl_err <= '0;
    end else begin
      out_valid    <= fwd_valid;
      out_tid      <= in_tid;
      out_seq      <= in_seq;
      out_pc       <= in_pc;
      out_pred_pc  <= pp_fix;
      out_ready    <= lane_ready & fwd_valid;
      kill_mask    <= kill_n;
      hold_mask    <= hold_n;
      rd_valid     <= stop_is_br;
      rd_tid       <= tid_a[stop_idx];
      rd_seq       <= seq_a[stop_idx];
      rd_npc       <= tgt_a[stop_idx];
      rd_nnpc      <= seq_pc(tgt_a[stop_idx]);
      rd_taken     <= left_sequence(pc_a[stop_idx], npc_a[stop_idx]);
      cerr_valid   <= stop_is_cerr;
      cerr_tid     <= tid_a[stop_idx];
      cerr_seq     <= seq_a[stop_idx];
      cnt_resolved <= cnt_resolved + res_add;
      cnt_mispred  <= cnt_mispred + CNT_W'(stop_is_br);
      cnt_ctrl_err <= cnt_ctrl_err + CNT_W'(stop_is_cerr);
    end
  end

  assign rd_mispredict = rd_valid;
  assign rd_pred_wrong = rd_valid;
  assign rd_squash     = rd_valid;
  assign rd_upc        = '0;
endmodule

// File: rtl/ebr_chk.sv
module ebr_chk
  import ebr_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_found,
  input logic [LANES-1:0] out_valid,
  input logic [LANES-1:0] kill_mask,
  input logic [LANES-1:0] hold_mask,
  input logic             rd_valid,
  input logic [PC_W-1:0]  rd_npc,
  input logic [PC_W-1:0]  rd_nnpc,
  input logic             cerr_valid,
  input logic [CNT_W-1:0] cnt_mispred,
  input logic [CNT_W-1:0] cnt_ctrl_err
);
  // R4
  nnpc_follows_npc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_nnpc == rd_npc + PC_W'(INST_BYTES));

  // R7
  killed_not_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_mask & out_valid) == '0);

  // R7
  masks_need_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_mask | hold_mask) != '0 |-> (rd_valid || cerr_valid));

  // R7
  stop_gives_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_found |=> (rd_valid || cerr_valid));

  // R8
  single_stop_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && cerr_valid));

  // R9
  mispred_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_mispred == $past(cnt_mispred) + CNT_W'(rd_valid));

  // R9
  ctrl_err_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ctrl_err == $past(cnt_ctrl_err) + CNT_W'(cerr_valid));
endmodule

bind early_branch_resolver ebr_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stop_found   (stop_found),
  .out_valid    (out_valid),
  .kill_mask    (kill_mask),
  .hold_mask    (hold_mask),
  .rd_valid     (rd_valid),
  .rd_npc       (rd_npc),
  .rd_nnpc      (rd_nnpc),
  .cerr_valid   (cerr_valid),
  .cnt_mispred  (cnt_mispred),
  .cnt_ctrl_err (cnt_ctrl_err)
);

// File: tb/tb_early_branch_resolver.sv
`timescale 1ns/1ps
module tb_early_branch_resolver;
  localparam int L = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [L-1:0]    in_valid, in_pred_taken, in_is_ctrl, in_is_direct, in_is_uncond;
  logic [L*1-1:0]  in_tid;
  logic [L*16-1:0] in_seq;
  logic [L*32-1:0] in_pc, in_npc, in_pred_pc, in_target;
  logic [L*3-1:0]  in_nsrc;
  logic [L-1:0]    out_valid, out_ready, kill_mask, hold_mask;
  logic [L*1-1:0]  out_tid;
  logic [L*16-1:0] out_seq;
  logic [L*32-1:0] out_pc, out_pred_pc;
  logic rd_valid, rd_mispredict, rd_pred_wrong, rd_squash, rd_taken, cerr_valid;
  logic rd_tid, cerr_tid;
  logic [15:0] rd_seq, cerr_seq, cnt_resolved, cnt_mispred, cnt_ctrl_err;
  logic [31:0] rd_npc, rd_nnpc;
  logic [7:0]  rd_upc;

  early_branch_resolver dut (.*);

  // Stimulus lane fields
  logic        s_v[L], s_tid[L], s_pt[L], s_c[L], s_d[L], s_u[L];
  logic [15:0] s_seq[L];
  logic [31:0] s_pc[L], s_npc[L], s_pp[L], s_tgt[L];
  logic [2:0]  s_ns[L];

  typedef struct {
    logic [L-1:0] ov, rdy, kill, hold;
    logic [15:0]  seq[L];
    logic [31:0]  pc[L], pp[L];
    logic         rd, rtid, rtaken, ce;
    logic [15:0]  rseq, ceseq, nres, nmis, nce;
    logic [31:0]  rnpc;
  } exp_t;

  exp_t q[$];
  int checks = 0, failures = 0;
  logic [15:0] m_res = 0, m_mis = 0, m_ce = 0;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_lanes();
    for (int i = 0; i < L; i++) begin
      s_v[i] = 0; s_tid[i] = 0; s_pt[i] = 0; s_c[i] = 0; s_d[i] = 0; s_u[i] = 0;
      s_seq[i] = 0; s_pc[i] = 0; s_npc[i] = 0; s_pp[i] = 0; s_tgt[i] = 0; s_ns[i] = 1;
    end
  endtask

  // Plain instruction at address a, sequence n
  task automatic plain(input int i, input logic t, input logic [15:0] n, input logic [31:0] a, input logic [2:0] ns);
    s_v[i] = 1; s_tid[i] = t; s_seq[i] = n; s_pc[i] = a; s_npc[i] = a + 4; s_pp[i] = a + 4; s_ns[i] = ns;
  endtask

  // Direct unconditional branch: predicted pp, real target tg, fetch next np
  task automatic jump(input int i, input logic t, input logic [15:0] n, input logic [31:0] a,
                      input logic [31:0] pp, input logic [31:0] tg, input logic [31:0] np);
    s_v[i] = 1; s_tid[i] = t; s_seq[i] = n; s_pc[i] = a; s_npc[i] = np; s_pp[i] = pp;
    s_tgt[i] = tg; s_c[i] = 1; s_d[i] = 1; s_u[i] = 1; s_pt[i] = 1; s_ns[i] = 0;
  endtask

  // Driver: drive bundle, model expected outcome, push to scoreboard
  task automatic send();
    exp_t e;
    int stop;
    @(negedge clk);
    for (int i = 0; i < L; i++) begin
      in_valid[i] = s_v[i]; in_tid[i] = s_tid[i]; in_pred_taken[i] = s_pt[i];
      in_is_ctrl[i] = s_c[i]; in_is_direct[i] = s_d[i]; in_is_uncond[i] = s_u[i];
      in_seq[i*16 +: 16] = s_seq[i]; in_pc[i*32 +: 32] = s_pc[i]; in_npc[i*32 +: 32] = s_npc[i];
      in_pred_pc[i*32 +: 32] = s_pp[i]; in_target[i*32 +: 32] = s_tgt[i]; in_nsrc[i*3 +: 3] = s_ns[i];
    end
    e.ov = 0; e.rdy = 0; e.kill = 0; e.hold = 0; e.rd = 0; e.ce = 0;
    e.rtid = 0; e.rtaken = 0; e.rseq = 0; e.ceseq = 0; e.rnpc = 0;
    stop = -1;
    for (int i = 0; i < L; i++) begin
      e.seq[i] = s_seq[i]; e.pc[i] = s_pc[i]; e.pp[i] = s_pp[i];
      if (!s_v[i]) continue;
      if (stop < 0) begin
        e.ov[i] = 1;
        e.rdy[i] = (s_ns[i] == 0);
        if (s_c[i] && s_d[i] && s_u[i]) begin
          m_res++;
          if (s_tgt[i] != s_pp[i]) begin
            stop = i; e.rd = 1; e.pp[i] = s_tgt[i]; m_mis++;
            e.rtid = s_tid[i]; e.rseq = s_seq[i]; e.rnpc = s_tgt[i];
            e.rtaken = (s_npc[i] != s_pc[i] + 32'd4);
          end
        end else if (s_pt[i] && !s_c[i]) begin
          stop = i; e.ce = 1; e.ceseq = s_seq[i]; m_ce++;
        end
      end else if (s_tid[i] == s_tid[stop] && s_seq[i] > s_seq[stop]) e.kill[i] = 1;
      else e.hold[i] = 1;
    end
    e.nres = m_res; e.nmis = m_mis; e.nce = m_ce;
    q.push_back(e);
  endtask

  // Monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(out_valid == e.ov, "R1 out_valid", 64'(out_valid), 64'(e.ov));
      chk(out_ready == e.rdy, "R2 out_ready", 64'(out_ready), 64'(e.rdy));
      for (int i = 0; i < L; i++) begin
        if (e.ov[i]) begin
          chk(out_seq[i*16 +: 16] == e.seq[i], "R1 seq", 64'(out_seq[i*16 +: 16]), 64'(e.seq[i]));
          chk(out_pc[i*32 +: 32] == e.pc[i], "R1 pc", 64'(out_pc[i*32 +: 32]), 64'(e.pc[i]));
          chk(out_pred_pc[i*32 +: 32] == e.pp[i], "R6 pred_pc", 64'(out_pred_pc[i*32 +: 32]), 64'(e.pp[i]));
        end
      end
      chk(kill_mask == e.kill, "R7 kill_mask", 64'(kill_mask), 64'(e.kill));
      chk(hold_mask == e.hold, "R7 hold_mask", 64'(hold_mask), 64'(e.hold));
      chk(rd_valid == e.rd, "R4 rd_valid", 64'(rd_valid), 64'(e.rd));
      if (e.rd) begin
        chk(rd_mispredict && rd_pred_wrong && rd_squash, "R4 flags",
            64'({rd_mispredict, rd_pred_wrong, rd_squash}), 64'h7);
        chk(rd_seq == e.rseq && rd_tid == e.rtid, "R4 seq/tid", 64'({rd_tid, rd_seq}), 64'({e.rtid, e.rseq}));
        chk(rd_npc == e.rnpc, "R4 npc", 64'(rd_npc), 64'(e.rnpc));
        chk(rd_nnpc == e.rnpc + 32'd4, "R4 nnpc", 64'(rd_nnpc), 64'(e.rnpc + 32'd4));
        chk(rd_upc == 0, "R4 upc", 64'(rd_upc), 64'h0);
        chk(rd_taken == e.rtaken, "R5 taken", 64'(rd_taken), 64'(e.rtaken));
      end
      chk(cerr_valid == e.ce, "R8 cerr_valid", 64'(cerr_valid), 64'(e.ce));
      if (e.ce) chk(cerr_seq == e.ceseq, "R8 cerr_seq", 64'(cerr_seq), 64'(e.ceseq));
      chk(cnt_resolved == e.nres, "R3 cnt_resolved", 64'(cnt_resolved), 64'(e.nres));
      chk(cnt_mispred == e.nmis, "R9 cnt_mispred", 64'(cnt_mispred), 64'(e.nmis));
      chk(cnt_ctrl_err == e.nce, "R9 cnt_ctrl_err", 64'(cnt_ctrl_err), 64'(e.nce));
    end
  end

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clear_lanes();
    in_valid = 0; in_tid = 0; in_seq = 0; in_pc = 0; in_npc = 0; in_pred_pc = 0; in_target = 0;
    in_pred_taken = 0; in_is_ctrl = 0; in_is_direct = 0; in_is_uncond = 0; in_nsrc = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(out_valid == 0 && kill_mask == 0 && hold_mask == 0, "R10 masks", 64'({out_valid, kill_mask, hold_mask}), 0);
    chk(!rd_valid && !cerr_valid, "R10 pulses", 64'({rd_valid, cerr_valid}), 0);
    chk(cnt_resolved == 0 && cnt_mispred == 0 && cnt_ctrl_err == 0, "R10 counters",
        64'({cnt_resolved, cnt_mispred, cnt_ctrl_err}), 0);

    // R1/R2: plain bundle, mixed source counts
    clear_lanes();
    plain(0, 0, 10, 32'h1000, 0); plain(1, 0, 11, 32'h1004, 2);
    plain(2, 1, 12, 32'h2000, 0); plain(3, 1, 13, 32'h2004, 5);
    send();
    // R3: correctly predicted jump resolved, no redirect
    clear_lanes();
    jump(0, 0, 20, 32'h1100, 32'h1800, 32'h1800, 32'h1800); plain(1, 0, 21, 32'h1800, 1);
    send();
    // R3: conditional and indirect branches with wrong prediction: ignored
    clear_lanes();
    jump(0, 0, 30, 32'h1200, 32'h1300, 32'h1400, 32'h1300); s_u[0] = 0;
    jump(1, 0, 31, 32'h1300, 32'h1500, 32'h1600, 32'h1500); s_d[1] = 0;
    plain(2, 0, 32, 32'h1500, 3);
    send();
    // R4/R5/R6/R7: mispredict in lane 1, not taken by fetch; kill and hold after
    clear_lanes();
    plain(0, 0, 40, 32'h3000, 1);
    jump(1, 0, 41, 32'h3004, 32'h3008, 32'h4000, 32'h3008); s_pt[1] = 0;
    plain(2, 0, 42, 32'h3008, 0); plain(3, 1, 43, 32'h5000, 0);
    send();
    // R8: control mispredict in lane 0 beats jump mispredict in lane 2
    clear_lanes();
    plain(0, 1, 50, 32'h6000, 0); s_pt[0] = 1; s_pp[0] = 32'h7000;
    plain(1, 1, 51, 32'h7000, 0);
    jump(2, 1, 52, 32'h7004, 32'h7100, 32'h7200, 32'h7100);
    plain(3, 0, 53, 32'h9000, 0);
    send();
    // R7: two mispredicts, lane 1 wins; lane 3 same thread but older -> hold; back to back
    clear_lanes();
    plain(0, 1, 60, 32'h8000, 2);
    jump(1, 1, 61, 32'h8004, 32'h8800, 32'h8400, 32'h8800);
    jump(2, 1, 62, 32'h8400, 32'h8500, 32'h8600, 32'h8500);
    plain(3, 1, 59, 32'h7ffc, 0);
    send();
    // R4/R5: mispredict in last lane, fetch took it; no masks
    clear_lanes();
    plain(0, 0, 70, 32'hA000, 0); plain(1, 1, 71, 32'hB000, 4); plain(2, 0, 72, 32'hA004, 0);
    jump(3, 0, 73, 32'hA008, 32'hA100, 32'hA200, 32'hA100);
    send();
    // R1: sparse lanes with idle gaps
    clear_lanes();
    plain(1, 1, 80, 32'hC000, 0); plain(3, 0, 81, 32'hD000, 7);
    send();
    clear_lanes();
    send();
    send();
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule